// File: doc/BRIEF.md
# Reset and Clock-Release Sequencer

This block brings a device out of reset in two phases. It first holds the system reset low for a time that depends on why the device was reset. After that, it keeps the system clock gated off until the selected clock source is ready. The hold time is built from three stages, counted in cycles of an always-running reference clock: a power-on settle, a regulator settle and a state-clear stage. A power-on cause runs all three stages, a brown-out runs the last two, and every other cause runs only the state-clear stage. Power-on has the highest priority, brown-out comes next, and the remaining causes come last. A cause that arrives while a sequence is in progress restarts it from the stage that cause maps to.

Once the reset is released, the clock gate waits on a condition chosen by the 3-bit source code. The possible waits are:
- an oscillator settle count of edges of the external oscillator;
- a fast on-chip RC start-up timer;
- a slow on-chip RC start-up timer;
- the PLL lock input.

With two-speed start-up, the system runs from the fast RC source as soon as that source is ready, and moves to the selected source once that source's own wait has finished. With the fail-safe monitor enabled, a counter of reference cycles watches the oscillator edge input. If no edge arrives within a set window, the block raises a clock-fail flag and switches the system to the fast RC source. The analog oscillator and the PLL are modelled as a per-period edge pulse and a lock level.

Top module: `boot_sequencer`

## Requirements
- R1: While rst_n is low (sampled on clk), sys_rst_n, clk_en and clk_fail are all 0 and the power-on stage is loaded at its first cycle. The reset load counts as that stage's first cycle, so if rst_n is high from edge f, sys_rst_n rises at edge f+PWR_CYC+REG_CYC+STATE_CYC-1.
- R2: cause_req bit 0 is the power-on cause and wins over all others. When it is sampled at edge k, sys_rst_n is 0 from edge k and becomes 1 at edge k+PWR_CYC+REG_CYC+STATE_CYC.
- R3: cause_req bit 1 is the brown-out cause. Without bit 0, it holds sys_rst_n low from edge k and releases it at edge k+REG_CYC+STATE_CYC.
- R4: cause_req bits 2 to 7 (pin, watchdog, software, illegal opcode, uninitialized register, trap conflict), with bits 0 and 1 clear, release sys_rst_n at edge k+STATE_CYC, whatever the source code.
- R5: A cause sampled at any time, including after release, restarts the sequence from its own stage at that edge. sys_rst_n is 0 and clk_en is 0 in the cycle after that edge.
- R6: Source codes: 0 external clock, 1 external with PLL, 2 crystal, 3 crystal with PLL, 4 fast RC, 5 fast RC with PLL, 6 slow RC, 7 divided fast RC (waits like 4). Let E be the release edge, and let r be the number of edges after E until the wait condition holds. Without two-speed and without a failure, clk_en rises at edge E+r+1 with act_src equal to the source code. Code 0 has r=0. Code 1 waits for pll_lock.
- R7: Codes 2 and 3 count osc_edge pulses from the cycle after E. The wait is met when OSC_CNT pulses have been counted (1024 by default). Code 3 also needs pll_lock.
- R8: Codes 4 and 7 give r=FAST_CYC. Code 5 needs FAST_CYC and pll_lock. Code 6 gives r=SLOW_CYC.
- R9: After the selected source is ready, clk_en stays 1 until the next cause, whatever pll_lock or the timers do.
- R10: With two_speed_en, clk_en rises at edge E+min(r+1, FAST_CYC). act_src is 4 until the selected source is ready, and equal to the source code afterwards.
- R11: The fail-safe monitor is armed only when failsafe_en is 1 and the source code is 0 to 3. After E, once MISS_CYC reference cycles have passed with no osc_edge, clk_fail is 1 from edge E+MISS_CYC+1 (for a stall starting at E). clk_fail stays 1 until the next cause.
- R12: While clk_fail is 1, act_src is 4 and clk_en follows the fast RC timer.
- R13: clk_en is 0 whenever sys_rst_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_req | input | 8 | Reset-cause requests, one bit per cause (see R2 to R4) |
| src_sel | input | 3 | Selected clock-source code (see R6) |
| two_speed_en | input | 1 | Start from the fast RC source first |
| failsafe_en | input | 1 | Arm the missing-edge clock monitor |
| osc_edge | input | 1 | One-cycle pulse per external oscillator period, already synchronized |
| pll_lock | input | 1 | PLL lock indication |
| sys_rst_n | output | 1 | System reset, active low |
| clk_en | output | 1 | System clock gate enable |
| act_src | output | 3 | Source code currently driving the system |
| clk_fail | output | 1 | Clock-fail trap flag |

## Verification
A stage counter that is off by one, or a cause priority that is wrong, shows up at the sys_rst_n rising edge as a release one or more cycles away from the expected edge. It is visible within the few dozen cycles of a single sequence. A wrong readiness decision for a source code, or a two-speed switch that goes the wrong way, moves the clk_en rise to another cycle or leaves the wrong code on act_src. The bench measures both against arithmetic expectations for every code and cause. A monitor window that is counted wrongly, or that is armed for the wrong codes, moves the clk_fail rise away from the cycle after the window ends, or makes it appear where it must not.

// File: rtl/boot_pkg.sv
// Package: shared types for the reset and clock-release sequencer.
// Assumes: 3-bit source codes and 8 reset-cause bits, fixed by the requirements.
package boot_pkg;

    localparam int CAUSE_W = 8;

    typedef enum logic [2:0] {
        SRC_EXT       = 3'd0,
        SRC_EXT_PLL   = 3'd1,
        SRC_XTAL      = 3'd2,
        SRC_XTAL_PLL  = 3'd3,
        SRC_FAST_RC   = 3'd4,
        SRC_FAST_PLL  = 3'd5,
        SRC_SLOW_RC   = 3'd6,
        SRC_FAST_DIV  = 3'd7
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_PWR   = 2'd0,
        ST_REG   = 2'd1,
        ST_STATE = 2'd2,
        ST_RUN   = 2'd3
    } rst_stage_e;

    // True for sources fed by the external oscillator pin (codes 0..3).
    function automatic logic src_uses_osc(input logic [2:0] s);
        return (s[2] == 1'b0);
    endfunction

endpackage

// File: rtl/boot_delay_timer.sv
// Module: saturating event counter used as a start-up timer.
// What: counts tick pulses from zero after clr drops, then holds at LIMIT and flags done.
// Assumes: LIMIT >= 1; clr has priority over tick.
module boot_delay_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count tick events up to LIMIT, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done); // R9

endmodule

// File: rtl/boot_reset_stager.sv
// Module: reset-cause driven stage sequencer.
// What: steps power-on, regulator and state-clear stages, each counted in
//       reference cycles, then reports release. Power-on cause beats brown-out,
//       brown-out beats the others; any cause restarts at its own stage.
// Assumes: every stage length >= 1 cycle.
module boot_reset_stager
    import boot_pkg::*;
#(
    parameter int PWR_CYC   = 1250,
    parameter int REG_CYC   = 1250,
    parameter int STATE_CYC = 250
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause,
    output logic               released
);
    localparam int M1   = (PWR_CYC > REG_CYC) ? PWR_CYC : REG_CYC;
    localparam int MAXC = (M1 > STATE_CYC) ? M1 : STATE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    rst_stage_e    stage;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Last count value of the current stage.
    always_comb begin
        case (stage)
            ST_PWR:   last = CW'(PWR_CYC - 1);
            ST_REG:   last = CW'(REG_CYC - 1);
            ST_STATE: last = CW'(STATE_CYC - 1);
            default:  last = '0;
        endcase
    end

    // Stage and counter update with cause priority and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || cause[0]) begin
            stage <= ST_PWR;
            cnt   <= '0;
        end else if (cause[1]) begin
            stage <= ST_REG;
            cnt   <= '0;
        end else if (|cause[CAUSE_W-1:2]) begin
            stage <= ST_STATE;
            cnt   <= '0;
        end else if (stage != ST_RUN) begin
            if (cnt == last) begin
                cnt <= '0;
                case (stage)
                    ST_PWR:  stage <= ST_REG;
                    ST_REG:  stage <= ST_STATE;
                    default: stage <= ST_RUN;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign released = (stage == ST_RUN);

    AST_CAUSE_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause) |=> !released); // R5
    AST_RELEASE_FROM_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> ($past(stage) == ST_STATE)); // R4
    AST_REG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_REG && $past(stage) != ST_REG) |->
        ($past(stage) == ST_PWR || $past(cause[1]))); // R3

endmodule

// File: rtl/boot_edge_monitor.sv
// Module: missing-edge clock monitor.
// What: counts reference cycles since the last oscillator edge while armed;
//       a full window of MISS_CYC cycles with no edge sets a sticky fail flag.
// Assumes: osc_edge is a synchronized one-cycle pulse; clr restarts the monitor.
module boot_edge_monitor #(
    parameter int MISS_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic osc_edge,
    output logic fail
);
    localparam int GW = $clog2(MISS_CYC + 1);
    localparam logic [GW-1:0] GLIM = GW'(MISS_CYC);

    logic [GW-1:0] gap;

    // Track the gap since the last edge, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || osc_edge) begin
            gap <= '0;
        end else if (arm && gap != GLIM) begin
            gap <= gap + 1'b1;
        end
    end

    // Latch the failure once the window has run out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail <= 1'b0;
        end else if (arm && gap == GLIM) begin
            fail <= 1'b1;
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> fail); // R11
    AST_FAIL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(arm)); // R11

endmodule

// File: rtl/boot_sequencer.sv
// Module: reset and clock-release sequencer (top).
// What: holds the system reset per reset cause, then gates the system clock
//       until the selected source is ready; offers two-speed start from the
//       fast RC source and a fail-safe fallback to it on missing edges.
// Assumes: src_sel, two_speed_en and failsafe_en are stable during a sequence;
//          osc_edge is already synchronized to clk; all lengths >= 1.
module boot_sequencer
    import boot_pkg::*;
#(
    parameter int PWR_CYC   = 1250,
    parameter int REG_CYC   = 1250,
    parameter int STATE_CYC = 250,
    parameter int OSC_CNT   = 1024,
    parameter int FAST_CYC  = 500,
    parameter int SLOW_CYC  = 2000,
    parameter int MISS_CYC  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] cause_req,
    input  logic [2:0]         src_sel,
    input  logic               two_speed_en,
    input  logic               failsafe_en,
    input  logic               osc_edge,
    input  logic               pll_lock,
    output logic               sys_rst_n,
    output logic               clk_en,
    output logic [2:0]         act_src,
    output logic               clk_fail
);
    localparam int NTMR = 3;
    localparam int TM_OSC  = 0;
    localparam int TM_FAST = 1;
    localparam int TM_SLOW = 2;

    logic            rel;
    logic [NTMR-1:0] tmr_tick;
    logic [NTMR-1:0] tmr_done;
    logic            prim_ready;
    logic            prim_done;
    logic            fail;

    boot_reset_stager #(
        .PWR_CYC   (PWR_CYC),
        .REG_CYC   (REG_CYC),
        .STATE_CYC (STATE_CYC)
    ) u_stager (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause    (cause_req),
        .released (rel)
    );

    assign tmr_tick[TM_OSC]  = osc_edge;
    assign tmr_tick[TM_FAST] = 1'b1;
    assign tmr_tick[TM_SLOW] = 1'b1;

    // One start-up timer per wait kind, each restarted while reset is held.
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        localparam int LIM = (g == TM_OSC)  ? OSC_CNT :
                             (g == TM_FAST) ? FAST_CYC : SLOW_CYC;
        boot_delay_timer #(.LIMIT(LIM)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (!rel),
            .tick  (tmr_tick[g]),
            .done  (tmr_done[g])
        );
    end

    boot_edge_monitor #(.MISS_CYC(MISS_CYC)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rel),
        .arm      (failsafe_en && src_uses_osc(src_sel)),
        .osc_edge (osc_edge),
        .fail     (fail)
    );

    // Readiness of the selected source from its timers and the PLL.
    always_comb begin
        case (src_sel)
            SRC_EXT:      prim_ready = 1'b1;
            SRC_EXT_PLL:  prim_ready = pll_lock;
            SRC_XTAL:     prim_ready = tmr_done[TM_OSC];
            SRC_XTAL_PLL: prim_ready = tmr_done[TM_OSC] && pll_lock;
            SRC_FAST_PLL: prim_ready = tmr_done[TM_FAST] && pll_lock;
            SRC_SLOW_RC:  prim_ready = tmr_done[TM_SLOW];
            default:      prim_ready = tmr_done[TM_FAST];
        endcase
    end

    // Sticky record that the selected source has been released.
    always_ff @(posedge clk) begin
        if (!rst_n || !rel) begin
            prim_done <= 1'b0;
        end else if (prim_ready) begin
            prim_done <= 1'b1;
        end
    end

    // Output gate and source selection: fallback, primary, then two-speed.
    always_comb begin
        if (fail || (rel && !prim_done && two_speed_en)) begin
            act_src = SRC_FAST_RC;
        end else begin
            act_src = src_sel;
        end
        if (!rel) begin
            clk_en = 1'b0;
        end else if (fail) begin
            clk_en = tmr_done[TM_FAST];
        end else if (prim_done) begin
            clk_en = 1'b1;
        end else begin
            clk_en = two_speed_en && tmr_done[TM_FAST];
        end
    end

    assign sys_rst_n = rel;
    assign clk_fail  = fail;

    AST_GATE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> !clk_en); // R13
    AST_FALLBACK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fail |-> (act_src == SRC_FAST_RC)); // R12
    AST_PRIMARY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_done && rel && !(|cause_req)) |=> prim_done); // R9
    AST_CLK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prim_done) |-> $past(rel)); // R6

endmodule

// File: tb/boot_sequencer_test.sv
`timescale 1ns/1ps
module boot_sequencer_test;
    localparam int TP = 5, TV = 4, TR = 3;
    localparam int OSCN = 8, FC = 6, SC = 10, MC = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cause_req = '0;
    logic [2:0] src_sel = '0;
    logic       two_speed_en = 1'b0;
    logic       failsafe_en = 1'b0;
    logic       osc_edge = 1'b1;
    logic       pll_lock = 1'b0;
    logic       sys_rst_n, clk_en, clk_fail;
    logic [2:0] act_src;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    boot_sequencer #(
        .PWR_CYC(TP), .REG_CYC(TV), .STATE_CYC(TR),
        .OSC_CNT(OSCN), .FAST_CYC(FC), .SLOW_CYC(SC), .MISS_CYC(MC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cause_req(cause_req), .src_sel(src_sel),
        .two_speed_en(two_speed_en), .failsafe_en(failsafe_en),
        .osc_edge(osc_edge), .pll_lock(pll_lock), .sys_rst_n(sys_rst_n),
        .clk_en(clk_en), .act_src(act_src), .clk_fail(clk_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset hold length expected for a cause vector.
    function automatic int hold_len(input logic [7:0] c);
        if (c[0]) return TP + TV + TR;
        if (c[1]) return TV + TR;
        return TR;
    endfunction

    // Edges after release until the selected source is ready.
    function automatic int ready_at(input int s, input int l);
        case (s)
            0: return 0;
            1: return l;
            2: return OSCN;
            3: return (OSCN > l) ? OSCN : l;
            5: return (FC > l) ? FC : l;
            6: return SC;
            default: return FC;
        endcase
    endfunction

    // Pulse a cause for one cycle, count low samples of sys_rst_n.
    task automatic run_cause(input logic [7:0] c, output int lows, output logic en0);
        cause_req = c;
        @(negedge clk);
        cause_req = '0;
        en0 = clk_en;
        lows = 0;
        while (!sys_rst_n && lows < 500) begin
            lows++;
            @(negedge clk);
        end
    endtask

    // Count low samples of clk_en after release, raising pll_lock at sample l.
    task automatic wait_clk(input int l, output int j, output logic [2:0] a);
        j = 0;
        while (!clk_en && j < 300) begin
            if (j == l) pll_lock = 1'b1;
            j++;
            @(negedge clk);
        end
        a = act_src;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int lows, j, exp;
        logic en0;
        logic [2:0] a;

        repeat (3) @(negedge clk);
        chk("R1 sys_rst_n in reset", sys_rst_n, 0);
        chk("R1 clk_en in reset", clk_en, 0);
        chk("R1 clk_fail in reset", clk_fail, 0);
        rst_n = 1'b1;
        @(negedge clk);
        lows = 0;
        while (!sys_rst_n && lows < 500) begin
            lows++;
            @(negedge clk);
        end
        chk("R1 release after reset", lows, TP + TV + TR - 1);

        run_cause(8'hFF, lows, en0);
        chk("R2 power-on wins", lows, TP + TV + TR);
        run_cause(8'hFE, lows, en0);
        chk("R3 brown-out over others", lows, TV + TR);

        for (int idx = 0; idx < 32; idx++) begin
            logic [7:0] c;
            int l, s, r;
            s = idx % 8;
            l = (idx / 16 != 0) ? 12 : 0;
            src_sel = 3'(s);
            two_speed_en = ((idx / 8) % 2) != 0;
            failsafe_en = ((idx / 4) % 2) != 0;
            osc_edge = 1'b1;
            pll_lock = 1'b0;
            c = 8'(1 << ((idx * 3) % 8));
            run_cause(c, lows, en0);
            if (c[0]) chk("R2 power-on hold", lows, hold_len(c));
            else if (c[1]) chk("R3 brown-out hold", lows, hold_len(c));
            else chk("R4 short-cause hold", lows, hold_len(c));
            r = ready_at(s, l);
            wait_clk(l, j, a);
            if (two_speed_en) begin
                exp = (r + 1 < FC) ? r + 1 : FC;
                chk("R10 two-speed clk_en rise", j, exp);
                chk("R10 two-speed source at rise", a, (r + 1 > FC) ? 4 : s);
            end else begin
                if (s < 2) chk("R6 external wait", j, r + 1);
                else if (s < 4) chk("R7 crystal wait", j, r + 1);
                else chk("R8 RC wait", j, r + 1);
                chk("R6 source at rise", a, s);
            end
            pll_lock = 1'b1;
            repeat (30) @(negedge clk);
            pll_lock = 1'b0;
            repeat (3) @(negedge clk);
            chk("R9 clk_en stays on", clk_en, 1);
            chk("R10 final source", act_src, s);
            chk("R11 no fail with edges", clk_fail, 0);
        end

        run_cause(8'h20, lows, en0);
        chk("R5 clk_en drops on cause", en0, 0);
        chk("R5 restart from running", lows, TR);

        cause_req = 8'h01;
        @(negedge clk);
        cause_req = '0;
        repeat (2) @(negedge clk);
        chk("R5 held mid power-on", sys_rst_n, 0);
        run_cause(8'h08, lows, en0);
        chk("R5 restart mid sequence", lows, TR);

        src_sel = 3'd2; two_speed_en = 1'b0; failsafe_en = 1'b1;
        osc_edge = 1'b0; pll_lock = 1'b0;
        run_cause(8'h04, lows, en0);
        j = 0;
        while (!clk_fail && j < 100) begin
            if (j == MC) chk("R7 gate closed before fail", clk_en, 0);
            j++;
            @(negedge clk);
        end
        chk("R11 fail after window", j, MC + 1);
        chk("R12 fallback clock on", clk_en, 1);
        chk("R12 fallback source", act_src, 4);
        osc_edge = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 fail sticky", clk_fail, 1);
        chk("R12 source stays fast RC", act_src, 4);

        failsafe_en = 1'b0; osc_edge = 1'b0;
        run_cause(8'h04, lows, en0);
        repeat (40) @(negedge clk);
        chk("R11 monitor disarmed", clk_fail, 0);
        chk("R7 stalled oscillator keeps gate", clk_en, 0);

        failsafe_en = 1'b1; src_sel = 3'd4;
        run_cause(8'h04, lows, en0);
        repeat (40) @(negedge clk);
        chk("R11 not armed for RC", clk_fail, 0);
        chk("R8 fast RC running", clk_en, 1);

        src_sel = 3'd2;
        run_cause(8'h04, lows, en0);
        for (int i = 0; i < 60; i++) begin
            osc_edge = (i % 3) == 0;
            @(negedge clk);
        end
        osc_edge = 1'b0;
        chk("R11 slow edges no fail", clk_fail, 0);
        chk("R7 sparse edges count", clk_en, 1);
        chk("R7 crystal source", act_src, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule